// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block is the numerically controlled oscillator of an analog television encoder. On each pixel-rate enable it advances a 32-bit phase, and a later sine/cosine lookup and quadrature modulator turn that phase into the colour subcarrier. The tuning scale puts a word of 0x80000000 at the pixel rate, so each pixel the phase grows by twice the selected word, wrapping modulo 2^32.

Software picks a TV standard and sets an 8-bit starting phase through a narrow write port. It can also load a 32-bit tuning word as two 16-bit halves. Without the custom-word option, the block uses a built-in word for the selected standard. The custom word carries variants such as a 525-line raster with the 4.43 MHz subcarrier. In SECAM mode a second accumulator runs for the blue-difference lines, and the main accumulator always runs on the programmed word as the red-difference centre frequency. Both accumulators return to the starting phase on a soft reset or at the start of a frame, so every frame begins with a known phase.

Top module: `subcarrier_nco`

## Requirements
- R1: After reset both phase outputs equal 0x28000000 (start phase 0x28 in bits 31:24). The programmed word resets to 0x29C71C72, the blue-line word to 0x284BDA13, the mode to 0, and the start phase to 0x28.
- R2: On each clock with `pix_en` high and no restart, a phase output that is running grows by twice its word, modulo 2^32. With `pix_en` low it holds.
- R3: The mode register (address 3) holds the standard code in bits 1:0, SECAM in bit 2 and custom in bit 3. With bits 2 and 3 clear, the main word is 0x21F07C1F for code 0, 0x2A098ACB for code 1, 0x21E6EFE3 for code 2 and 0x21F69446 for code 3.
- R4: With custom (bit 3) set and SECAM clear, the main accumulator runs on the programmed word, whatever the standard code.
- R5: With SECAM (bit 2) set, the main accumulator runs on the programmed word whatever the custom bit and standard code hold.
- R6: The blue-line accumulator advances only while SECAM is set. Otherwise it holds, and after a restart it stays at the start phase.
- R7: Address 0 stages the upper half of the programmed word and does not change the word in use. A write to address 1 commits the staged upper half together with the written lower half in one step.
- R8: Address 2 sets the start phase (bits 7:0). A new start phase has no effect on the outputs until the next restart, which loads it into bits 31:24 with the lower bits cleared.
- R9: `soft_rst` or `frame_start` restarts both accumulators at the start phase on the next edge, and a restart takes priority over a pixel advance in the same cycle.
- R10: The blue-line word is staged in the same way: upper half at address 4, commit with the lower half at address 5. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Restart both accumulators at the start phase |
| frame_start | input | 1 | Frame-start restart pulse |
| pix_en | input | 1 | Pixel-rate advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| dr_phase | output | 32 | Main (red-difference in SECAM) subcarrier phase |
| db_phase | output | 32 | Blue-difference SECAM phase |

## Verification
Assertions check on every cycle that each accumulator steps by exactly twice its word or holds, and that a restart loads the start phase. They also check that an upper-half write alone never changes a word in use, that a lower-half write commits both halves, that SECAM makes the main word the programmed one, and that unused addresses leave every register untouched. Only the bench's scenarios can show the values themselves. These are the built-in word for each standard code, the custom override on 525-line variants, the blue-line word and its idle behaviour outside SECAM, and the delayed effect of a new start phase.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int OFS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;

    localparam logic [ADDR_W-1:0] A_WORD_HI = 3'd0;
    localparam logic [ADDR_W-1:0] A_WORD_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_OFS     = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODE    = 3'd3;
    localparam logic [ADDR_W-1:0] A_DB_HI   = 3'd4;
    localparam logic [ADDR_W-1:0] A_DB_LO   = 3'd5;

    typedef enum logic [1:0] {
        STD_NTSC = 2'd0,
        STD_PAL  = 2'd1,
        STD_PALM = 2'd2,
        STD_PALN = 2'd3
    } tv_std_e;

    typedef struct packed {
        logic    custom;
        logic    secam;
        tv_std_e std_sel;
    } mode_t;

    function automatic logic [WORD_W-1:0] builtin_word(tv_std_e s);
        case (s)
            STD_PAL:  return 32'h2A098ACB;
            STD_PALM: return 32'h21E6EFE3;
            STD_PALN: return 32'h21F69446;
            default:  return 32'h21F07C1F;
        endcase
    endfunction
endpackage

// File: rtl/nco_regs.sv
module nco_regs
    import nco_pkg::*;
#(
    parameter logic [WORD_W-1:0] DR_RST = 32'h29C71C72,
    parameter logic [WORD_W-1:0] DB_RST = 32'h284BDA13,
    parameter logic [OFS_W-1:0]  OFS_RST = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [WORD_W-1:0] prog_word,
    output logic [WORD_W-1:0] db_word,
    output logic [OFS_W-1:0]  start_ofs,
    output mode_t             mode
);
    typedef struct packed {
        logic [HALF_W-1:0] hi_stage;
        logic [WORD_W-1:0] word;
        logic [HALF_W-1:0] db_hi_stage;
        logic [WORD_W-1:0] db;
        logic [OFS_W-1:0]  ofs;
        mode_t             mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                A_WORD_HI: r_d.hi_stage    = wr_data;
                A_WORD_LO: r_d.word        = {r_q.hi_stage, wr_data};
                A_OFS:     r_d.ofs         = wr_data[OFS_W-1:0];
                A_MODE:    r_d.mode        = mode_t'(wr_data[3:0]);
                A_DB_HI:   r_d.db_hi_stage = wr_data;
                A_DB_LO:   r_d.db          = {r_q.db_hi_stage, wr_data};
                default:   r_d             = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.hi_stage    <= DR_RST[WORD_W-1:HALF_W];
            r_q.word        <= DR_RST;
            r_q.db_hi_stage <= DB_RST[WORD_W-1:HALF_W];
            r_q.db          <= DB_RST;
            r_q.ofs         <= OFS_RST;
            r_q.mode        <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_word = r_q.word;
    assign db_word   = r_q.db;
    assign start_ofs = r_q.ofs;
    assign mode      = r_q.mode;

    assert_hi_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_WORD_HI) |=> $stable(r_q.word));
    assert_lo_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_WORD_LO) |=> r_q.word == {$past(r_q.hi_stage), $past(wr_data)});
    assert_db_lo_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DB_LO) |=> r_q.db == {$past(r_q.db_hi_stage), $past(wr_data)});
    assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_DB_LO) |=> $stable(r_q));
endmodule

// File: rtl/nco_word_sel.sv
module nco_word_sel
    import nco_pkg::*;
(
    input  mode_t             mode,
    input  logic [WORD_W-1:0] prog_word,
    output logic [WORD_W-1:0] main_word
);
    always_comb begin
        if (mode.secam || mode.custom) main_word = prog_word;
        else                           main_word = builtin_word(mode.std_sel);
    end
endmodule

// File: rtl/nco_accum.sv
module nco_accum
    import nco_pkg::*;
#(
    parameter logic [OFS_W-1:0] OFS_RST = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              adv,
    input  logic [WORD_W-1:0] word,
    input  logic [OFS_W-1:0]  start_ofs,
    output logic [WORD_W-1:0] phase
);
    localparam int LOW_W = WORD_W - OFS_W;

    typedef struct packed {
        logic [WORD_W-1:0] ph;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (restart)  a_d.ph = {start_ofs, {LOW_W{1'b0}}};
        else if (adv) a_d.ph = a_q.ph + {word[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q.ph <= {OFS_RST, {LOW_W{1'b0}}};
        else        a_q    <= a_d;
    end

    assign phase = a_q.ph;

    assert_restart_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> phase == {$past(start_ofs), {LOW_W{1'b0}}});
    assert_step_twice_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart) |=> phase == $past(phase) + ($past(word) << 1));
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !restart) |=> $stable(phase));
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
    import nco_pkg::*;
#(
    parameter logic [WORD_W-1:0] DR_RST  = 32'h29C71C72,
    parameter logic [WORD_W-1:0] DB_RST  = 32'h284BDA13,
    parameter logic [OFS_W-1:0]  OFS_RST = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              frame_start,
    input  logic              pix_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [WORD_W-1:0] dr_phase,
    output logic [WORD_W-1:0] db_phase
);
    logic [WORD_W-1:0] prog_word, db_word, main_word;
    logic [OFS_W-1:0]  start_ofs;
    mode_t             mode;
    logic              restart;
    logic [WORD_W-1:0] step_a  [NUM_CH];
    logic              adv_a   [NUM_CH];
    logic [WORD_W-1:0] phase_a [NUM_CH];

    nco_regs #(.DR_RST(DR_RST), .DB_RST(DB_RST), .OFS_RST(OFS_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_word(prog_word), .db_word(db_word),
        .start_ofs(start_ofs), .mode(mode)
    );

    nco_word_sel u_sel (.mode(mode), .prog_word(prog_word), .main_word(main_word));

    assign restart   = soft_rst | frame_start;
    assign step_a[0] = main_word;
    assign step_a[1] = db_word;
    assign adv_a[0]  = pix_en;
    assign adv_a[1]  = pix_en & mode.secam;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        nco_accum #(.OFS_RST(OFS_RST)) u_acc (
            .clk(clk), .rst_n(rst_n), .restart(restart), .adv(adv_a[g]),
            .word(step_a[g]), .start_ofs(start_ofs), .phase(phase_a[g])
        );
    end

    assign dr_phase = phase_a[0];
    assign db_phase = phase_a[1];

    assert_secam_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode.secam |-> main_word == prog_word);
    assert_db_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.secam && !restart) |=> $stable(db_phase));
endmodule

// File: tb/sim_subcarrier_nco.sv
`timescale 1ns/1ps
module sim_subcarrier_nco;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, frame_start = 1'b0, pix_en = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] dr_phase, db_phase;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    subcarrier_nco u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_start(frame_start),
        .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dr_phase(dr_phase), .db_phase(db_phase)
    );

    function automatic logic [31:0] expect_ph(logic [7:0] ofs, logic [31:0] w, int n);
        logic [31:0] p = {ofs, 24'h0};
        for (int i = 0; i < n; i++) p = p + (w << 1);
        return p;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run(int n);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0; pix_en = 1'b1;
        repeat (n) @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dr reset", dr_phase, 32'h28000000);
        check("R1 db reset", db_phase, 32'h28000000);
        run(1);
        check("R1 reset word is NTSC builtin", dr_phase, expect_ph(8'h28, 32'h21F07C1F, 1));
    endtask

    task automatic t_builtin();
        logic [31:0] w [4] = '{32'h21F07C1F, 32'h2A098ACB, 32'h21E6EFE3, 32'h21F69446};
        for (int s = 0; s < 4; s++) begin
            wr(3'd3, 16'(s));
            run(5 + s);
            check("R3 builtin word", dr_phase, expect_ph(8'h28, w[s], 5 + s));
            check("R6 db idle outside SECAM", db_phase, 32'h28000000);
        end
    endtask

    task automatic t_hold();
        wr(3'd3, 16'h0);
        run(4);
        repeat (3) @(negedge clk);
        check("R2 hold without pix_en", dr_phase, expect_ph(8'h28, 32'h21F07C1F, 4));
    endtask

    task automatic t_custom();
        wr(3'd0, 16'h2A09); wr(3'd1, 16'h8ACB);
        wr(3'd3, 16'h0008);
        run(6);
        check("R4 custom on NTSC code", dr_phase, expect_ph(8'h28, 32'h2A098ACB, 6));
        wr(3'd3, 16'h000A);
        run(3);
        check("R4 custom on PAL-M code", dr_phase, expect_ph(8'h28, 32'h2A098ACB, 3));
    endtask

    task automatic t_stage();
        wr(3'd0, 16'h1234);
        run(3);
        check("R7 upper half alone no effect", dr_phase, expect_ph(8'h28, 32'h2A098ACB, 3));
        wr(3'd1, 16'h5678);
        run(3);
        check("R7 commit on lower half", dr_phase, expect_ph(8'h28, 32'h12345678, 3));
        wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
        run(2);
        check("R10 unused address no effect", dr_phase, expect_ph(8'h28, 32'h12345678, 2));
    endtask

    task automatic t_secam();
        wr(3'd3, 16'h0004);
        run(5);
        check("R5 SECAM uses programmed word", dr_phase, expect_ph(8'h28, 32'h12345678, 5));
        check("R6 db runs in SECAM", db_phase, expect_ph(8'h28, 32'h284BDA13, 5));
        wr(3'd0, 16'h29C7); wr(3'd1, 16'h1C72);
        wr(3'd3, 16'h000D);
        run(4);
        check("R5 SECAM ignores custom and code", dr_phase, expect_ph(8'h28, 32'h29C71C72, 4));
        wr(3'd4, 16'h1111);
        run(2);
        check("R10 db upper half alone", db_phase, expect_ph(8'h28, 32'h284BDA13, 2));
        wr(3'd5, 16'h2222);
        run(4);
        check("R10 db commit", db_phase, expect_ph(8'h28, 32'h11112222, 4));
    endtask

    task automatic t_offset();
        wr(3'd3, 16'h0);
        run(2);
        wr(3'd2, 16'h0080);
        check("R8 new start phase waits", dr_phase, expect_ph(8'h28, 32'h21F07C1F, 2));
        run(0);
        check("R8 restart loads start phase", dr_phase, 32'h80000000);
        run(3);
        check("R8 run from new start phase", dr_phase, expect_ph(8'h80, 32'h21F07C1F, 3));
    endtask

    task automatic t_frame();
        run(3);
        @(negedge clk); frame_start = 1'b1; pix_en = 1'b1;
        @(negedge clk); frame_start = 1'b0; pix_en = 1'b0;
        check("R9 frame restart beats advance", dr_phase, 32'h80000000);
        @(negedge clk); pix_en = 1'b1;
        repeat (2) @(negedge clk);
        pix_en = 1'b0;
        check("R9 run after frame restart", dr_phase, expect_ph(8'h80, 32'h21F07C1F, 2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_builtin();
        t_hold();
        t_custom();
        t_stage();
        t_secam();
        t_offset();
        t_frame();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule